// File: doc/BRIEF.md
# I2C Master Byte Engine

This block is a single-master I2C controller that performs one bus phase per software command. A host issues Start, Repeated Start, Stop, receive-a-byte and acknowledge commands on a small command port. It starts a byte transmission by writing the transmit data register, and that write is the trigger. Each operation runs to completion on its own. The engine then pulses its interrupt output and returns to idle, ready for the next command.

The bus lines are open-drain. The engine therefore only produces pull-low enables for SCL and SDA, and it reads the resolved SDA level back through `sda_in`. A programmable reload value sets the length of every SCL half-period. Status outputs show a pending transmit byte, a transmit in progress, the acknowledge level returned by the slave, and a collision flag for commands that arrive while the engine is busy.

Top module: `i2cm_master`

## Requirements
- R1: After reset both pull enables are 0 (lines released), and `busy`, `irq`, `tx_full`, `tx_active`, `wcol` and `ack_nack` are 0.
- R2: Every bus phase lasts `brg_reload`+1 clocks, and a reload of 0 acts as 1. A Start pulls SDA low while SCL stays released for one phase, then pulls SCL low.
- R3: A Repeated Start releases SDA while SCL is low, releases SCL, pulls SDA low while SCL is high, then pulls SCL low. The bus shows a '1' bit and then a Start condition.
- R4: A Stop pulls SDA low, releases SCL, then releases SDA while SCL is high, which leaves both lines released.
- R5: Writing `tx_data` with `tx_wr` while idle sends the byte MSB first. Each bit is driven during SCL low and changes only after SCL has fallen. A ninth slot then releases SDA and latches the sampled level into `ack_nack` (0 = ACK, 1 = NACK).
- R6: `tx_full` and `tx_active` rise on the accepted write. `tx_full` clears once the last data bit has been clocked, before the acknowledge slot ends. `tx_active` clears when the transmission completes.
- R7: A receive command runs eight SCL pulses with SDA released. It samples SDA at the end of each high phase, MSB first, and presents the byte on `rx_data` on completion.
- R8: An acknowledge command runs one SCL pulse. It pulls SDA low if `cmd_nack` is 0 and leaves SDA released if `cmd_nack` is 1, and SDA keeps that level after completion.
- R9: `irq` is a one-cycle pulse when each operation completes, and `busy` is 0 in the same cycle.
- R10: A command or transmit write that arrives while busy is ignored and sets `wcol`. A simultaneous write and command while idle starts the transmit, ignores the command and sets `wcol`. `wcol` clears when the next operation is accepted.
- R11: `cmd_op` codes are 1 = Start, 2 = Repeated Start, 3 = Stop, 4 = Receive, 5 = Acknowledge. Codes 0, 6 and 7 are ignored and change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| brg_reload | input | BRG_W | Phase length minus one, in clocks |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 3 | Command code |
| cmd_nack | input | 1 | For the acknowledge command: 1 sends NACK |
| tx_wr | input | 1 | Transmit register write strobe, starts a byte transmit |
| tx_data | input | DATA_W | Byte to transmit |
| sda_in | input | 1 | Resolved SDA line level |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |
| busy | output | 1 | An operation is running |
| irq | output | 1 | One-cycle completion pulse |
| tx_full | output | 1 | Transmit byte not yet fully shifted |
| tx_active | output | 1 | Master transmit in progress |
| ack_nack | output | 1 | Acknowledge level sampled after the last transmit |
| wcol | output | 1 | Command or write collided with a busy engine |
| rx_data | output | DATA_W | Last received byte |

## Verification
The hardest case to reach is a collision: a command has to land while a byte is being shifted, or in the same cycle as a transmit write. The engine must ignore it without leaving any trace on the bus. The stimulus injects a Stop command in the middle of a transmit, and it also writes a byte together with a Start command. A bus monitor decodes every SCL rise and every Start and Stop condition and compares them against an expected-event queue, so a stray condition caused by a leaked command shows up as a mismatch. A bench slave model drives acknowledge and receive data only after SCL has fallen. This exercises both ACK and NACK returns and two different received bytes.

// File: rtl/i2cm_pkg.sv
// Shared codes for the I2C master byte engine: command codes, FSM states
// and the line-level table for Start, Repeated Start and Stop sequences.
package i2cm_pkg;
    timeunit 1ns; timeprecision 1ps;

    localparam logic [2:0] OP_START  = 3'd1;
    localparam logic [2:0] OP_RSTART = 3'd2;
    localparam logic [2:0] OP_STOP   = 3'd3;
    localparam logic [2:0] OP_RECV   = 3'd4;
    localparam logic [2:0] OP_ACK    = 3'd5;
    localparam logic [2:0] OP_TX     = 3'd7;   // internal only, never accepted from cmd_op

    typedef enum logic [1:0] {ST_IDLE, ST_COND, ST_LO, ST_HI} i2cm_state_e;

    // Returns {last_step, scl_pull, sda_pull} for a condition step.
    // Exactly one line changes between consecutive steps.
    function automatic logic [2:0] cond_step(logic [2:0] op, logic [1:0] step);
        logic [2:0] r;
        r = 3'b100;
        case (op)
            OP_START:  r = (step == 2'd0) ? 3'b001 : 3'b111;
            OP_RSTART: case (step)
                           2'd0:    r = 3'b010;
                           2'd1:    r = 3'b000;
                           2'd2:    r = 3'b001;
                           default: r = 3'b111;
                       endcase
            OP_STOP:   case (step)
                           2'd0:    r = 3'b011;
                           2'd1:    r = 3'b001;
                           default: r = 3'b100;
                       endcase
            default:   r = 3'b100;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/i2cm_baud.sv
// Phase timer. It is reloaded when an operation is accepted and counts
// down while running, pulsing tick once every reload+1 clocks.
// Assumes reload is non-zero (the top clamps it).
module i2cm_baud #(
    parameter int BRG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic [BRG_W-1:0] reload,
    output logic             tick
);
    timeunit 1ns; timeprecision 1ps;

    logic [BRG_W-1:0] cnt_q;

    // Down-counter with reload on accept and on every expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= reload;
        else if (run)
            cnt_q <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
    end

    assign tick = run && !load && (cnt_q == '0);

    // R2: once a phase ends, the next one cannot end in the following cycle
    a_r2_no_back_to_back_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && reload != '0) |=> !tick);
endmodule

// File: rtl/i2cm_shifter.sv
// Byte shift register shared by transmit and receive. It loads parallel
// data on a transmit accept and shifts left, taking in sin at the LSB.
module i2cm_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              shift,
    input  logic              sin,
    output logic [DATA_W-1:0] q
);
    timeunit 1ns; timeprecision 1ps;

    // Parallel load has priority over shifting.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= din;
        else if (shift)
            q <= {q[DATA_W-2:0], sin};
    end
endmodule

// File: rtl/i2cm_ctrl.sv
// Operation sequencer. It accepts one command or transmit write while
// idle, walks condition steps or bit slots on each phase tick, and
// owns the line pull registers and all status flags. SDA data changes
// one clock after SCL has been pulled low. Assumes sda_in is already
// synchronous to clk.
module i2cm_ctrl
    import i2cm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic              cmd_nack,
    input  logic              tx_wr,
    input  logic              sda_in,
    input  logic              tick,
    input  logic [DATA_W-1:0] sh_q,
    output logic              accept,
    output logic              load_tx,
    output logic              shift,
    output logic              busy,
    output logic              scl_pull,
    output logic              sda_pull,
    output logic              irq,
    output logic              tx_full,
    output logic              tx_active,
    output logic              ack_nack,
    output logic              wcol,
    output logic [DATA_W-1:0] rx_data
);
    timeunit 1ns; timeprecision 1ps;

    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(DATA_W - 1);

    i2cm_state_e      state_q;
    logic [2:0]       op_q;
    logic [1:0]       step_q;
    logic [CNT_W-1:0] bit_q;
    logic             nack_q;
    logic             cmd_ok, acc_cmd, collide, drive_bit;
    logic [CNT_W-1:0] last_bit;
    logic [2:0]       cs_cur, cs_nxt, cs_first;

    assign busy     = (state_q != ST_IDLE);
    assign cmd_ok   = cmd_valid && (cmd_op >= OP_START) && (cmd_op <= OP_ACK);
    assign load_tx  = tx_wr && !busy;
    assign acc_cmd  = cmd_ok && !busy && !tx_wr;
    assign accept   = load_tx || acc_cmd;
    assign collide  = (busy && (tx_wr || cmd_valid)) || (!busy && tx_wr && cmd_valid);
    assign cs_cur   = cond_step(op_q, step_q);
    assign cs_nxt   = cond_step(op_q, step_q + 2'd1);
    assign cs_first = cond_step(cmd_op, 2'd0);
    assign shift    = (state_q == ST_HI) && tick && (op_q == OP_TX || op_q == OP_RECV)
                      && (bit_q != LAST_TX);

    // Final bit slot index of the running byte operation.
    always_comb begin
        case (op_q)
            OP_TX:   last_bit = LAST_TX;
            OP_RECV: last_bit = LAST_RX;
            default: last_bit = '0;
        endcase
    end

    // SDA pull level wanted during the low phase of the current slot.
    always_comb begin
        case (op_q)
            OP_TX:   drive_bit = (bit_q != LAST_TX) ? !sh_q[DATA_W-1] : 1'b0;
            OP_ACK:  drive_bit = !nack_q;
            default: drive_bit = 1'b0;
        endcase
    end

    // Main sequencer: accept, condition steps, bit slots, flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            op_q      <= '0;
            step_q    <= '0;
            bit_q     <= '0;
            nack_q    <= 1'b0;
            scl_pull  <= 1'b0;
            sda_pull  <= 1'b0;
            irq       <= 1'b0;
            tx_full   <= 1'b0;
            tx_active <= 1'b0;
            ack_nack  <= 1'b0;
            wcol      <= 1'b0;
            rx_data   <= '0;
        end else begin
            irq <= 1'b0;
            if (collide)
                wcol <= 1'b1;
            else if (accept)
                wcol <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (load_tx) begin
                        op_q      <= OP_TX;
                        bit_q     <= '0;
                        tx_full   <= 1'b1;
                        tx_active <= 1'b1;
                        scl_pull  <= 1'b1;
                        state_q   <= ST_LO;
                    end else if (acc_cmd) begin
                        op_q   <= cmd_op;
                        nack_q <= cmd_nack;
                        step_q <= '0;
                        bit_q  <= '0;
                        if (cmd_op == OP_RECV || cmd_op == OP_ACK) begin
                            scl_pull <= 1'b1;
                            state_q  <= ST_LO;
                        end else begin
                            scl_pull <= cs_first[1];
                            sda_pull <= cs_first[0];
                            state_q  <= ST_COND;
                        end
                    end
                end
                ST_COND: begin
                    if (tick) begin
                        if (cs_cur[2]) begin
                            state_q <= ST_IDLE;
                            irq     <= 1'b1;
                        end else begin
                            step_q   <= step_q + 2'd1;
                            scl_pull <= cs_nxt[1];
                            sda_pull <= cs_nxt[0];
                        end
                    end
                end
                ST_LO: begin
                    sda_pull <= drive_bit;
                    if (tick) begin
                        scl_pull <= 1'b0;
                        state_q  <= ST_HI;
                    end
                end
                ST_HI: begin
                    if (tick) begin
                        scl_pull <= 1'b1;
                        if (op_q == OP_TX && bit_q == LAST_RX)
                            tx_full <= 1'b0;
                        if (op_q == OP_TX && bit_q == LAST_TX)
                            ack_nack <= sda_in;
                        if (op_q == OP_RECV && bit_q == LAST_RX)
                            rx_data <= {sh_q[DATA_W-2:0], sda_in};
                        if (bit_q == last_bit) begin
                            state_q   <= ST_IDLE;
                            irq       <= 1'b1;
                            tx_active <= 1'b0;
                        end else begin
                            bit_q   <= bit_q + 1'b1;
                            state_q <= ST_LO;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R9: completion pulse lasts one cycle and coincides with idle
    a_r9_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    a_r9_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (!busy && $past(busy)));
    // R10: a busy-time strobe is flagged and does not change the operation
    a_r10_collision_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (cmd_valid || tx_wr)) |=> (wcol && $stable(op_q)));
    // R5: outside conditions, SDA never moves while SCL stays released
    a_r5_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_COND && $past(state_q) != ST_COND && !scl_pull && $past(!scl_pull))
        |-> $stable(sda_pull));
    // R6: buffer-full only rises after a write, transmit flag implies busy
    a_r6_full_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_full) |-> $past(tx_wr));
    a_r6_active_busy: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active |-> busy);
endmodule

// File: rtl/i2cm_master.sv
// I2C master byte engine top: phase timer, shift register and sequencer.
// Assumes open-drain pads outside and a synchronised sda_in.
module i2cm_master #(
    parameter int DATA_W = 8,
    parameter int BRG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BRG_W-1:0]  brg_reload,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic              cmd_nack,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              sda_in,
    output logic              scl_pull,
    output logic              sda_pull,
    output logic              busy,
    output logic              irq,
    output logic              tx_full,
    output logic              tx_active,
    output logic              ack_nack,
    output logic              wcol,
    output logic [DATA_W-1:0] rx_data
);
    timeunit 1ns; timeprecision 1ps;

    logic [BRG_W-1:0]  eff_reload;
    logic              tick, accept, load_tx, shift;
    logic [DATA_W-1:0] sh_q;

    assign eff_reload = (brg_reload == '0) ? BRG_W'(1) : brg_reload;

    i2cm_baud #(.BRG_W(BRG_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(busy), .load(accept),
        .reload(eff_reload), .tick(tick)
    );

    i2cm_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load_tx), .din(tx_data),
        .shift(shift), .sin(sda_in), .q(sh_q)
    );

    i2cm_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_nack(cmd_nack), .tx_wr(tx_wr), .sda_in(sda_in), .tick(tick),
        .sh_q(sh_q), .accept(accept), .load_tx(load_tx), .shift(shift),
        .busy(busy), .scl_pull(scl_pull), .sda_pull(sda_pull), .irq(irq),
        .tx_full(tx_full), .tx_active(tx_active), .ack_nack(ack_nack),
        .wcol(wcol), .rx_data(rx_data)
    );

    // R1: nothing is pulled in the first cycle out of reset
    a_r1_released_after_reset: assert property (@(posedge clk)
        (!rst_n) |=> (!scl_pull && !sda_pull && !busy));
endmodule

// File: tb/i2cm_master_test.sv
// Scoreboard bench: driver tasks push expected bus events into a queue.
// A bus monitor pops and compares each decoded SCL rise, Start and Stop.
module i2cm_master_test;
    timeunit 1ns; timeprecision 1ps;

    localparam int DW = 8;
    localparam int BW = 8;
    localparam int WATCHDOG = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [BW-1:0] brg = 8'd3;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic          cmd_nack = 1'b0;
    logic          tx_wr = 1'b0;
    logic [DW-1:0] tx_data = '0;
    logic          slv_pull = 1'b0;
    logic          scl_pull, sda_pull, busy, irq, tx_full, tx_active, ack_nack, wcol;
    logic [DW-1:0] rx_data;
    logic          scl_b, sda_b;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    exp_q[$];
    string tag_q[$];
    bit    mon_en = 1'b0;

    assign scl_b = !scl_pull;
    assign sda_b = !(sda_pull || slv_pull);

    always #2.5 clk = ~clk;

    i2cm_master #(.DATA_W(DW), .BRG_W(BW)) uut (
        .clk(clk), .rst_n(rst_n), .brg_reload(brg), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_nack(cmd_nack), .tx_wr(tx_wr), .tx_data(tx_data),
        .sda_in(sda_b), .scl_pull(scl_pull), .sda_pull(sda_pull), .busy(busy),
        .irq(irq), .tx_full(tx_full), .tx_active(tx_active), .ack_nack(ack_nack),
        .wcol(wcol), .rx_data(rx_data)
    );

    function automatic void chk(string tag, int act, int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endfunction

    function automatic void push(int v, string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endfunction

    // Event codes: 0/1 = bit seen at SCL rise, 2 = Start, 3 = Stop.
    function automatic void got(int v);
        if (exp_q.size() == 0)
            chk("R10 unexpected bus event", v, -1);
        else
            chk(tag_q.pop_front(), v, exp_q.pop_front());
    endfunction

    always @(posedge scl_b) if (mon_en) got(int'(sda_b));
    always @(negedge sda_b) if (mon_en && scl_b) got(2);
    always @(posedge sda_b) if (mon_en && scl_b) got(3);

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
        summary();
        $finish;
    end

    task automatic send_cmd(logic [2:0] op, logic nack);
        @(negedge clk);
        cmd_op = op; cmd_nack = nack; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(string tag);
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (irq) break;
        end
        chk({tag, " irq seen with busy low"}, int'(busy), 0);
        @(negedge clk);
        chk({tag, " irq lasts one cycle"}, int'(irq), 0);
    endtask

    task automatic measure_start(int exp_len);
        int n;
        push(2, "R2 start condition");
        send_cmd(3'd1, 1'b0);
        chk("R2 sda pulled first", int'(sda_pull), 1);
        chk("R2 scl released in first phase", int'(scl_pull), 0);
        n = 0;
        while (!scl_pull && n < 1000) begin
            @(negedge clk);
            n++;
        end
        chk("R2 phase length", n, exp_len);
        wait_done("R9 start");
    endtask

    task automatic tx_byte(logic [7:0] b, bit slave_ack, bit collide_mid, bit both);
        for (int i = 7; i >= 0; i--) push(int'(b[i]), "R5 data bit");
        push(slave_ack ? 0 : 1, "R5 ack slot");
        fork
            begin
                repeat (8) @(negedge scl_b);
                #1 slv_pull = slave_ack;
                @(negedge scl_b);
                #1 slv_pull = 1'b0;
            end
            begin
                @(negedge clk);
                tx_data = b; tx_wr = 1'b1;
                if (both) begin cmd_op = 3'd1; cmd_valid = 1'b1; end
                @(negedge clk);
                tx_wr = 1'b0; cmd_valid = 1'b0;
                chk("R6 tx_full after write", int'(tx_full), 1);
                chk("R6 tx_active after write", int'(tx_active), 1);
                if (both) chk("R10 write with command sets wcol", int'(wcol), 1);
                if (collide_mid) begin
                    @(negedge clk);
                    cmd_op = 3'd3; cmd_valid = 1'b1;
                    @(negedge clk);
                    cmd_valid = 1'b0;
                    chk("R10 busy command sets wcol", int'(wcol), 1);
                end
                for (int k = 0; k < 20000 && tx_full; k++) @(negedge clk);
                chk("R6 tx_full clears before ack slot ends", int'(busy), 1);
                wait_done("R9 transmit");
                chk("R5 ack_nack latched", int'(ack_nack), slave_ack ? 0 : 1);
                chk("R6 tx_active clears at completion", int'(tx_active), 0);
            end
        join
    endtask

    task automatic rx_byte(logic [7:0] b);
        for (int i = 7; i >= 0; i--) push(int'(b[i]), "R7 received bit");
        slv_pull = !b[7];
        fork
            begin
                for (int i = 6; i >= 0; i--) begin
                    @(negedge scl_b);
                    #1 slv_pull = !b[i];
                end
                @(negedge scl_b);
                #1 slv_pull = 1'b0;
            end
            begin
                send_cmd(3'd4, 1'b0);
                wait_done("R9 receive");
                chk("R7 rx_data", int'(rx_data), int'(b));
            end
        join
    endtask

    task automatic ack_op(bit nack);
        push(nack ? 1 : 0, "R8 acknowledge bit");
        send_cmd(3'd5, nack);
        wait_done("R9 acknowledge");
        chk("R8 sda level held after acknowledge", int'(sda_pull), nack ? 0 : 1);
    endtask

    task automatic rstart(bit check_wcol);
        push(1, "R3 released bit before restart");
        push(2, "R3 restart condition");
        send_cmd(3'd2, 1'b0);
        if (check_wcol) chk("R10 wcol cleared by accepted command", int'(wcol), 0);
        wait_done("R9 repeated start");
    endtask

    task automatic stop_op();
        push(0, "R4 low bit before stop");
        push(3, "R4 stop condition");
        send_cmd(3'd3, 1'b0);
        wait_done("R9 stop");
        chk("R4 scl released", int'(scl_pull), 0);
        chk("R4 sda released", int'(sda_pull), 0);
    endtask

    initial begin
        bit seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 scl_pull", int'(scl_pull), 0);
        chk("R1 sda_pull", int'(sda_pull), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 tx_full", int'(tx_full), 0);
        chk("R1 tx_active", int'(tx_active), 0);
        chk("R1 wcol", int'(wcol), 0);
        chk("R1 ack_nack", int'(ack_nack), 0);
        mon_en = 1'b1;

        measure_start(4);
        tx_byte(8'hA5, 1'b1, 1'b0, 1'b0);
        tx_byte(8'h3C, 1'b0, 1'b0, 1'b0);
        rstart(1'b0);
        tx_byte(8'h91, 1'b1, 1'b1, 1'b0);
        rx_byte(8'hC6);
        ack_op(1'b0);
        rx_byte(8'h5A);
        ack_op(1'b1);
        rstart(1'b0);
        tx_byte(8'h0F, 1'b1, 1'b0, 1'b1);
        rstart(1'b1);

        // R11: unused command code leaves everything untouched
        send_cmd(3'd6, 1'b0);
        seen = 1'b0;
        repeat (20) begin
            @(negedge clk);
            if (busy || irq) seen = 1'b1;
        end
        chk("R11 unused code starts nothing", int'(seen), 0);
        chk("R11 scl still held low", int'(scl_pull), 1);
        chk("R11 wcol untouched", int'(wcol), 0);

        stop_op();
        brg = 8'd0;
        measure_start(2);
        stop_op();
        repeat (4) @(negedge clk);
        chk("R5 all expected bus events observed", exp_q.size(), 0);
        summary();
        $finish;
    end
endmodule